// File: doc/BRIEF.md
# Serial Scan Register Access Port

This block sits behind an external test access port controller and turns serial data-register scans into single accesses on a parallel register bus. It shifts a 40-bit frame in from `tdi` and out on `tdo`, least significant bit first. The frame holds a direction flag, a 7-bit register address and a 32-bit data word. The controller supplies capture, shift and update enables, and all logic runs on the debug clock.

When the controller signals update, the frame becomes one register access. A set direction flag issues a write of the data word. A clear flag issues a read. A read does not return its value in the scan that requested it. The bus reply is held, and the next capture state loads it into the data field. The result therefore comes out one scan later.

A host that streams words out of a buffer's data address sends that address once per word. On the last scan it sends a harmless address such as 0, so the final shift-out does not consume an extra word.

Top module: `scan_reg_port`

## Requirements
- R1: After a synchronous active-high reset, `tdo` is 0, `bus_rd` and `bus_wr` are low, and `bus_addr` and `bus_wdata` are 0. The first capture after reset returns a data field of 0.
- R2: The frame is 40 bits, with the data word in bits 31:0, the address in bits 38:32 and the direction flag in bit 39. Each cycle with `shift_en` high (and `capture_en` low) presents frame bit 0 on `tdo` before the shift edge, and moves `tdi` into bit 39.
- R3: On an update whose frame has direction 1, `bus_wr` pulses high for one cycle in the cycle after the update edge. During that pulse `bus_addr` carries bits 38:32 of the frame and `bus_wdata` carries bits 31:0. `bus_rd` stays low.
- R4: On an update whose frame has direction 0, `bus_rd` pulses high for one cycle with `bus_addr` set from the frame, and `bus_wr` stays low.
- R5: Holding `update_en` high for several cycles issues exactly one strobe.
- R6: `bus_rdata` is sampled at the clock edge that ends the `bus_rd` pulse. The next capture loads that value into bits 31:0 and zeros into bits 39:32.
- R7: A write access leaves the held read value unchanged, so a scan that follows a write returns the result of the last read.
- R8: In cycles with none of `capture_en`, `shift_en` or `update_en` high, the frame and `tdo` keep their values and no strobe is issued.
- R9: Each read update issues exactly one bus read. A stream of reads to the buffer data address (4) therefore consumes one word per scan. A final read of address 0 consumes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Capture state: load held read data into the frame |
| shift_en | input | 1 | Shift state: move the frame one bit toward `tdo` |
| update_en | input | 1 | Update state: issue the access described by the frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, frame bit 0 |
| bus_addr | output | 7 | Register address of the current access |
| bus_wdata | output | 32 | Write data of the current access |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read reply, valid while `bus_rd` is high |

## Verification
The embedded properties are checked on every cycle. They cover:
- the bit movement of a shift;
- the zero upper bits after a capture;
- read and write strobes never being high together, and each lasting one cycle;
- the held read value staying put without a read strobe;
- the frame staying frozen in idle cycles.

Only the bench's scan sequences can show the one-scan read latency and that a write does not disturb the held read result. They also show that a buffer stream ending on address 0 consumes no extra word, with the results checked against values the bench wrote or preloaded itself.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    // packed MSB-first, so bit 0 is the first bit shifted out
    typedef struct packed {
        logic              dir;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } access_e;

    function automatic frame_t capture_frame(input logic [DATA_W-1:0] d);
        frame_t f;
        f.dir  = 1'b0;
        f.addr = '0;
        f.data = d;
        return f;
    endfunction

    function automatic access_e decode_access(input logic dir);
        return dir ? ACC_WRITE : ACC_READ;
    endfunction
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter
    import scan_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] load_data,
    output frame_t            frame_q,
    output logic              tdo
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (capture_en) begin
            sr_q <= capture_frame(load_data);
        end else if (shift_en) begin
            sr_q <= {tdi, sr_q[FRAME_W-1:1]};
        end
    end

    assign frame_q = frame_t'(sr_q);
    assign tdo     = sr_q[0];

    assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !capture_en) |=>
            (sr_q[FRAME_W-1] == $past(tdi)) && (sr_q[FRAME_W-2:0] == $past(sr_q[FRAME_W-1:1])));

    assert_capture_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> (sr_q[FRAME_W-1:DATA_W] == '0));

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!capture_en && !shift_en) |=> $stable(sr_q));
endmodule

// File: rtl/scan_access_issue.sv
module scan_access_issue
    import scan_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              update_en,
    input  frame_t            frame_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd
);
    logic    upd_seen_q;
    logic    upd_edge;
    access_e acc_q;

    assign upd_edge = update_en && !upd_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_seen_q <= 1'b0;
            acc_q      <= ACC_NONE;
            bus_addr   <= '0;
            bus_wdata  <= '0;
        end else begin
            upd_seen_q <= update_en;
            if (upd_edge) begin
                acc_q     <= decode_access(frame_q.dir);
                bus_addr  <= frame_q.addr;
                bus_wdata <= frame_q.data;
            end else begin
                acc_q <= ACC_NONE;
            end
        end
    end

    assign bus_wr = (acc_q == ACC_WRITE);
    assign bus_rd = (acc_q == ACC_READ);

    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));

    assert_no_strobe_without_update_R8: assert property (@(posedge clk) disable iff (rst)
        !update_en |=> !(bus_wr || bus_rd));
endmodule

// File: rtl/scan_read_hold.sv
module scan_read_hold
    import scan_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (bus_rd)
            hold_q <= bus_rdata;
    end

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(hold_q));

    assert_hold_loads_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (hold_q == $past(bus_rdata)));
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import scan_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);
    frame_t            frame_q;
    logic [DATA_W-1:0] hold_q;

    scan_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .load_data  (hold_q),
        .frame_q    (frame_q),
        .tdo        (tdo)
    );

    scan_access_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .update_en (update_en),
        .frame_q   (frame_q),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd)
    );

    scan_read_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .hold_q    (hold_q)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!bus_wr && !bus_rd && !tdo));

    assert_one_read_per_update_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> $rose(update_en) || $past(update_en));
endmodule

// File: tb/test_scan_reg_port.sv
module test_scan_reg_port;
    localparam int PERIOD = 10;
    localparam logic [6:0] RAM_ADDR = 7'd4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic tdo, bus_wr, bus_rd;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    scan_reg_port i_scan_reg_port (
        .clk(clk), .rst(rst), .capture_en(cap), .shift_en(sh), .update_en(upd),
        .tdi(tdi), .tdo(tdo), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // register slave: 128 registers, address 4 streams words from a small buffer
    logic [31:0] regs [128];
    logic [31:0] ram [16];
    int ram_ptr = 0;
    int strobes = 0;

    initial begin
        for (int i = 0; i < 128; i++) regs[i] = 32'h0;
        regs[0] = 32'h0E7B_0001;
        for (int i = 0; i < 16; i++) ram[i] = 32'hC0DE_0000 + i;
    end

    function automatic logic [31:0] slave_read(input logic [6:0] a);
        return (a == RAM_ADDR) ? ram[ram_ptr[3:0]] : regs[a];
    endfunction

    always_comb bus_rdata = slave_read(bus_addr);

    always @(posedge clk) begin
        if (!rst && bus_wr) regs[bus_addr] <= bus_wdata;
        if (!rst && bus_rd && bus_addr == RAM_ADDR) ram_ptr <= ram_ptr + 1;
        if (!rst && (bus_rd || bus_wr)) strobes <= strobes + 1;
    end

    // behavioural reference: bit queue plus pending access
    bit          m_q[$];
    logic        m_upd_prev, m_rd, m_wr;
    logic [6:0]  m_addr;
    logic [31:0] m_wdata, m_hold;

    task automatic m_clear();
        m_q.delete();
        for (int i = 0; i < 40; i++) m_q.push_back(1'b0);
    endtask

    always @(posedge clk) begin
        logic [31:0] n_hold;
        logic [39:0] snap;
        if (rst) begin
            m_clear();
            m_upd_prev = 0; m_rd = 0; m_wr = 0; m_addr = 0; m_wdata = 0; m_hold = 0;
        end else begin
            for (int i = 0; i < 40; i++) snap[i] = m_q[i];
            n_hold = m_rd ? slave_read(m_addr) : m_hold;
            if (upd && !m_upd_prev) begin
                m_wr = snap[39]; m_rd = !snap[39];
                m_addr = snap[38:32]; m_wdata = snap[31:0];
            end else begin
                m_wr = 0; m_rd = 0;
            end
            m_upd_prev = upd;
            if (cap) begin
                m_q.delete();
                for (int i = 0; i < 40; i++) m_q.push_back(i < 32 ? m_hold[i] : 1'b0);
            end else if (sh) begin
                void'(m_q.pop_front());
                m_q.push_back(tdi);
            end
            m_hold = n_hold;
        end
    end

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 tdo", {39'b0, tdo}, {39'b0, m_q[0]});
            chk("R3 bus_wr", {39'b0, bus_wr}, {39'b0, m_wr});
            chk("R4 bus_rd", {39'b0, bus_rd}, {39'b0, m_rd});
            chk("R3 bus_addr", {33'b0, bus_addr}, {33'b0, m_addr});
            chk("R3 bus_wdata", {8'b0, bus_wdata}, {8'b0, m_wdata});
        end
    end

    task automatic scan(input logic dir, input logic [6:0] a, input logic [31:0] d,
                        input int upd_len, output logic [39:0] got);
        logic [39:0] fr;
        fr = {dir, a, d};
        @(negedge clk) cap = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) cap = 0; sh = 1; tdi = fr[i]; got[i] = tdo;
        end
        @(negedge clk) sh = 0; upd = 1;
        for (int i = 1; i < upd_len; i++) @(negedge clk);
        @(negedge clk) upd = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [39:0] g;
        int s0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {bus_wr, bus_rd, tdo, bus_addr, 31'b0}, 40'b0);
        chk("R1 wdata", {8'b0, bus_wdata}, 40'b0);
        rst = 0;
        @(negedge clk);

        // R3: write reg 5; first capture returns 0 (R1)
        scan(1'b1, 7'd5, 32'hA5A5_0F0F, 1, g);
        chk("R1 first capture", g, 40'b0);
        chk("R3 reg5 written", {8'b0, regs[5]}, {8'b0, 32'hA5A5_0F0F});

        // R4/R6: read reg 5, result appears on the next scan
        s0 = strobes;
        scan(1'b0, 7'd5, 32'h0, 1, g);
        chk("R4 one strobe on read", s0 + 1, strobes);
        scan(1'b0, 7'd0, 32'h0, 1, g);
        chk("R6 data of reg5", g, {8'b0, 32'hA5A5_0F0F});
        chk("R6 upper bits zero", {32'b0, g[39:32]}, 40'b0);

        // R9: buffer stream, final scan to address 0
        scan(1'b0, RAM_ADDR, 32'h0, 1, g);
        chk("R6 ident", g, {8'b0, 32'h0E7B_0001});
        scan(1'b0, RAM_ADDR, 32'h0, 1, g);
        chk("R9 word0", g, {8'b0, 32'hC0DE_0000});
        scan(1'b0, RAM_ADDR, 32'h0, 1, g);
        chk("R9 word1", g, {8'b0, 32'hC0DE_0001});
        scan(1'b0, 7'd0, 32'h0, 1, g);
        chk("R9 word2", g, {8'b0, 32'hC0DE_0002});
        scan(1'b0, RAM_ADDR, 32'h0, 1, g);
        chk("R9 ident at end", g, {8'b0, 32'h0E7B_0001});
        scan(1'b0, 7'd0, 32'h0, 1, g);
        chk("R9 no word skipped", g, {8'b0, 32'hC0DE_0003});

        // R7: write between read and its result
        scan(1'b0, 7'd5, 32'h0, 1, g);
        scan(1'b1, 7'd6, 32'h1234_5678, 1, g);
        chk("R7 result after read", g, {8'b0, 32'hA5A5_0F0F});
        scan(1'b0, 7'd0, 32'h0, 1, g);
        chk("R7 write left hold", g, {8'b0, 32'hA5A5_0F0F});
        chk("R3 reg6 written", {8'b0, regs[6]}, {8'b0, 32'h1234_5678});

        // R5: long update
        s0 = strobes;
        scan(1'b1, 7'd7, 32'hDEAD_BEEF, 4, g);
        chk("R5 single strobe", s0 + 1, strobes);
        chk("R5 reg7 written", {8'b0, regs[7]}, {8'b0, 32'hDEAD_BEEF});

        // R8: idle cycles, tdo and strobes compared each cycle
        s0 = strobes;
        tdi = 1;
        repeat (10) @(negedge clk);
        chk("R8 no strobe in idle", s0, strobes);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule